// File: doc/BRIEF.md
# Embedded-Clock Word Serializer with Sync Insertion

This block turns a stream of 10-bit parallel words into a single serial line running at twelve bits per word. Each word is wrapped in two embedded clock bits, a one in front and a zero behind, so the line rises at least once at every frame boundary and a receiver can recover the word clock from the data itself. One fast clock drives the block; a word lasts twelve of its cycles, and the block accepts a new word with a one-cycle `data_ready` strobe in the final bit cycle of the frame before.

Two sync-request inputs, of equal weight, replace payload with a fixed synchronization frame: six ones then six zeros, which has exactly one rising edge per frame. Any request sends at least 1024 sync frames, even a request of one cycle that falls in the middle of a frame. Holding a request stretches the burst. After reset the block sends 1024 sync frames on its own before it asks for its first word.

Top module: `ec_word_serializer`

## Requirements
- R1: A data frame is 12 serial bits, one per clock, in this order: a clock bit of 1, payload bits 0 through 9 (least significant first), then a clock bit of 0.
- R2: A sync frame is 12 serial bits: six cycles of 1 followed by six cycles of 0.
- R3: If `sync_a` or `sync_b` is high in a frame's last bit cycle, the next frame is a sync frame and `data_ready` is low in that cycle.
- R4: A request on either input, including a single-cycle pulse at any bit position, starts a burst of exactly 1024 sync frames, counted from the first frame that follows the request.
- R5: While a request is present at successive frame boundaries, sync frames continue; after the last boundary where a request was present, 1023 further sync frames follow before data resumes.
- R6: After reset is released, exactly 1024 sync frames are sent before the first data frame.
- R7: `data_ready` is high for one clock, in the last bit cycle of a frame, only when the next frame carries data; `data_in` is sampled at the clock edge ending that cycle.
- R8: While reset is asserted, `ser_out` and `data_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, twelve cycles per word |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 10 | Payload word, sampled when `data_ready` is high |
| sync_a | input | 1 | First sync request |
| sync_b | input | 1 | Second sync request |
| data_ready | output | 1 | Word-accept strobe for the next frame |
| ser_out | output | 1 | Serial frame output |

## Verification
The payload accept and a sync request can land on the same clock: a request raised in the very cycle where `data_ready` would rise must win, drop the strobe in that cycle and turn the frame that was about to carry data into the first of 1024 sync frames. The bench provokes this by raising a request at the frame boundary right after a stretch of data frames, checks that `data_ready` is low there, and counts the sync run that follows down to the frame. A one-cycle pulse inside a data frame, a long held request and both inputs together are judged the same way, by the run length and by comparing each frame bit for bit with the expected pattern.

// File: rtl/ec_word_serializer.sv
module ec_word_serializer #(
  parameter int W           = 10,
  parameter int SYNC_MIN    = 1024,
  parameter int INIT_FRAMES = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] data_in,
  input  logic         sync_a,
  input  logic         sync_b,
  output logic         data_ready,
  output logic         ser_out
);
  localparam int FL   = W + 2;
  localparam int CW   = $clog2(FL);
  localparam int LMAX = (SYNC_MIN > INIT_FRAMES) ? SYNC_MIN : INIT_FRAMES;
  localparam int SCW  = $clog2(LMAX + 1);
  localparam logic [FL-1:0] SYNC_WORD = {{(FL/2){1'b0}}, {(FL-FL/2){1'b1}}};

  logic [CW-1:0]  bit_cnt;
  logic [FL-1:0]  shreg;
  logic [SCW-1:0] sync_left;
  logic           req_seen;

  wire last      = (bit_cnt == CW'(FL-1));
  wire req_now   = req_seen | sync_a | sync_b;
  wire send_sync = req_now | (sync_left != '0);

  assign data_ready = last & ~send_sync;
  assign ser_out    = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= CW'(FL-1);
      shreg     <= '0;
      sync_left <= SCW'(INIT_FRAMES);
      req_seen  <= 1'b0;
    end else if (last) begin
      bit_cnt  <= '0;
      req_seen <= 1'b0;
      if (send_sync) begin
        shreg     <= SYNC_WORD;
        sync_left <= req_now ? SCW'(SYNC_MIN-1) : sync_left - 1'b1;
      end else begin
        shreg <= {1'b0, data_in, 1'b1};
      end
    end else begin
      bit_cnt  <= bit_cnt + 1'b1;
      shreg    <= shreg >> 1;
      req_seen <= req_now;
    end
  end
endmodule

module ec_word_serializer_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] data_in,
  input logic         sync_a,
  input logic         sync_b,
  input logic         data_ready,
  input logic         ser_out
);
  p_lead_clock_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> ser_out);

  p_payload_lsb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> ##2 (ser_out == $past(data_in[0], 2)));

  p_trail_clock_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> ##12 !ser_out);

  p_request_blocks_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_a || sync_b) |-> !data_ready);

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !data_ready);
endmodule

bind ec_word_serializer ec_word_serializer_chk #(.W(W)) u_chk (.*);

// File: tb/sim_ec_word_serializer.sv
module sim_ec_word_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] data_in = '0;
  logic       sync_a = 1'b0;
  logic       sync_b = 1'b0;
  logic       data_ready;
  logic       ser_out;

  int checks = 0;
  int fails  = 0;
  int rem    = 1024;
  bit pend   = 0;

  always #2.5 clk = ~clk;

  ec_word_serializer u0 (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .sync_a(sync_a),
    .sync_b(sync_b), .data_ready(data_ready), .ser_out(ser_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge just before a frame-load edge
  task automatic frame(input logic [9:0] d, input logic sa, input logic sb,
                       input bit midp, output bit was_sync);
    logic [11:0] got, expv;
    bit req, exp_sync;
    data_in = d; sync_a = sa; sync_b = sb;
    req = sa | sb | pend;
    pend = 0;
    exp_sync = req || (rem > 0);
    if (exp_sync) rem = req ? 1023 : rem - 1;
    #1;
    check(data_ready == !exp_sync, (sa | sb) ? "R3" : "R7", data_ready, !exp_sync);
    for (int i = 0; i < 12; i++)
      expv[i] = exp_sync ? (i < 6) : (i == 0) ? 1'b1 : (i == 11) ? 1'b0 : d[i-1];
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      got[i] = ser_out;
      if (i == 0) begin sync_a = 0; sync_b = 0; end
      if (midp && i == 4) begin sync_b = 1; pend = 1; end
      if (midp && i == 5) sync_b = 0;
    end
    check(got == expv, exp_sync ? "R2" : "R1", got, expv);
    was_sync = (got == 12'h03F);
  endtask

  task automatic count_run(input int expn, input string req);
    int n = 0;
    bit s = 1;
    while (s && n < 3000) begin
      frame(10'($urandom), 0, 0, 0, s);
      if (s) n++;
    end
    check(n == expn, req, n, expn);
  endtask

  initial begin
    bit s;
    repeat (3) begin
      @(negedge clk);
      check(ser_out == 0 && data_ready == 0, "R8", {ser_out, data_ready}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    count_run(1024, "R6");
    foreach (data_in[b]) frame(10'(1 << b), 0, 0, 0, s);
    frame(10'h000, 0, 0, 0, s);
    frame(10'h3FF, 0, 0, 0, s);
    frame(10'h155, 0, 0, 0, s);
    frame(10'h2AA, 0, 0, 0, s);
    repeat (40) frame(10'($urandom), 0, 0, 0, s);
    // request coincides with what would be a data accept cycle
    frame(10'h123, 1, 0, 0, s);
    count_run(1023, "R4");
    frame(10'h0F0, 0, 0, 0, s);
    frame(10'h00F, 0, 0, 1, s);
    count_run(1024, "R4");
    frame(10'h3C3, 1, 1, 0, s);
    count_run(1023, "R3");
    repeat (1500) frame(10'($urandom), 0, 1, 0, s);
    count_run(1023, "R5");
    repeat (10) frame(10'($urandom), 0, 0, 0, s);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule